// File: doc/BRIEF.md
# Six-Tap Half-Sample Interpolation Filter

This block produces half-position samples for sub-pixel motion refinement. Unsigned pixels arrive one per cycle, qualified by a valid strobe. They are pushed into a six-deep shift window. Each accepted pixel drops the oldest window entry.

Once six pixels have been accepted since the last clear, every further accepted pixel yields one output sample. The window is reduced by a single fused weighted sum with mirror-symmetric weights (1, -5, 20, 20, -5, 1). The sum is then rounded, divided by 32 and clamped into the pixel range. A clear input empties the window at row boundaries.

The arithmetic variant is a parameter. One variant pre-adds the mirrored sample pairs before weighting. The other weights all six samples individually. Both give identical results.

Top module: `halfpel_fir6`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: An accepted pixel (`in_valid`=1, `clear`=0) enters the window as its newest entry. Every other entry moves one place older, and the oldest of the six is discarded.
- R3: With the six most recent accepted pixels named q0 (oldest) to q5 (newest), the raw sum is S = q0 - 5*q1 + 20*q2 + 20*q3 - 5*q4 + q5. It is formed without overflow for every input combination.
- R4: The result before clamping is floor((S + 16) / 32), that is, an arithmetic right shift by 5 after adding 16.
- R5: A result below 0 is output as 0, and a result above 255 is output as 255. `out_data` is an unsigned 8-bit pixel.
- R6: The sixth accepted pixel after reset or clear, and every accepted pixel after it, produces `out_valid`=1 in the cycle directly following its acceptance. The `out_data` in that cycle is computed from the window that includes that pixel.
- R7: A cycle with `in_valid`=0 leaves the window and the fill count unchanged. In the next cycle `out_valid` is 0, and `out_data` holds its previous value.
- R8: `clear`=1 empties the window. A pixel presented in the same cycle is discarded. The next cycle has `out_valid`=0, and no output follows until six new pixels have been accepted.
- R9: `out_valid` is 1 only in the cycle directly after a cycle with `in_valid`=1 and `clear`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Empties the window and restarts the fill count |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | PIX_W | Unsigned input pixel |
| out_valid | output | 1 | One-cycle strobe for a new interpolated sample |
| out_data | output | PIX_W | Interpolated, clamped pixel; holds between strobes |

## Verification
The assertions assume that `clear` and `in_valid` are only meaningful in cycles where reset is released. They also assume that `in_data` is a plain unsigned pixel with no reserved codes, so any value is legal input.

The checker keeps its own count of accepted pixels since the last clear, and ties `out_valid` to that count and to the previous cycle's handshake. The stimulus changes inputs only on falling edges. It mixes back-to-back pixels, idle gaps and clears that land on pixel cycles, so every handshake combination the properties cover actually occurs.

// File: rtl/halfpel_pkg.sv
package halfpel_pkg;

   // Arithmetic variant of the six-operand weighted sum.
   typedef enum logic [0:0] {
      SUM_PREADD = 1'b0,  // add mirrored pairs, then weight three pair sums
      SUM_DIRECT = 1'b1   // weight each of the six samples on its own
   } sum_arch_e;

   // Number of window entries; the weighting is fixed to this length.
   localparam int unsigned WIN_DEPTH = 6;

   // Weight magnitudes; the middle pair carries a negative sign.
   localparam int unsigned W_EDGE   = 1;
   localparam int unsigned W_MID    = 5;
   localparam int unsigned W_CENTRE = 20;

   // Narrowest signed width that holds the sum for a given pixel width.
   function automatic int unsigned min_acc_width(input int unsigned pix_w);
      return pix_w + 7;
   endfunction

endpackage

// File: rtl/hp_window.sv
module hp_window
   import halfpel_pkg::*;
#(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned DEPTH = WIN_DEPTH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [PIX_W-1:0]           din,
   output logic [DEPTH-1:0][PIX_W-1:0] win_nxt,
   output logic                       fire
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

   logic [DEPTH-1:0][PIX_W-1:0] win_q;
   logic [CNT_W-1:0]            cnt_q;
   logic                        take;

   assign take = push && !clr;

   // Entry 0 is the newest sample; entry DEPTH-1 is the oldest.
   assign win_nxt[0] = clr ? '0 : (take ? din : win_q[0]);

   for (genvar i = 1; i < DEPTH; i++) begin : g_shift
      assign win_nxt[i] = clr ? '0 : (take ? win_q[i-1] : win_q[i]);
   end

   assign fire = take && (cnt_q >= CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         cnt_q <= '0;
      end else begin
         win_q <= win_nxt;
         if (clr) begin
            cnt_q <= '0;
         end else if (take && cnt_q != CNT_FULL) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hp_tapsum.sv
module hp_tapsum
   import halfpel_pkg::*;
#(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned ACC_W = 15,
   parameter sum_arch_e   ARCH  = SUM_PREADD
) (
   input  logic [WIN_DEPTH-1:0][PIX_W-1:0] win,
   output logic signed [ACC_W-1:0]         acc
);

   localparam int unsigned PAIR_W = PIX_W + 1;

   // Positions relative to the interpolation point:
   // win[5] = -2, win[4] = -1, win[3] = 0, win[2] = 1, win[1] = 2, win[0] = 3.
   function automatic logic signed [ACC_W-1:0] ext(input logic [PAIR_W-1:0] v);
      return $signed({{(ACC_W-PAIR_W){1'b0}}, v});
   endfunction

   // x*20 = x*16 + x*4 ; x*5 = x*4 + x
   function automatic logic signed [ACC_W-1:0] times20(input logic signed [ACC_W-1:0] v);
      return (v <<< 4) + (v <<< 2);
   endfunction

   function automatic logic signed [ACC_W-1:0] times5(input logic signed [ACC_W-1:0] v);
      return (v <<< 2) + v;
   endfunction

   if (ARCH == SUM_PREADD) begin : g_preadd
      logic [PAIR_W-1:0] p_edge, p_mid, p_ctr;
      assign p_edge = {1'b0, win[5]} + {1'b0, win[0]};
      assign p_mid  = {1'b0, win[4]} + {1'b0, win[1]};
      assign p_ctr  = {1'b0, win[3]} + {1'b0, win[2]};
      assign acc = ext(p_edge) - times5(ext(p_mid)) + times20(ext(p_ctr));
   end else begin : g_direct
      logic signed [ACC_W-1:0] term [WIN_DEPTH];
      for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_term
         if (i == 0 || i == WIN_DEPTH - 1) begin : g_e
            assign term[i] = ext({1'b0, win[i]});
         end else if (i == 1 || i == WIN_DEPTH - 2) begin : g_m
            assign term[i] = -times5(ext({1'b0, win[i]}));
         end else begin : g_c
            assign term[i] = times20(ext({1'b0, win[i]}));
         end
      end
      assign acc = term[0] + term[1] + term[2] + term[3] + term[4] + term[5];
   end

endmodule

// File: rtl/hp_normsat.sv
module hp_normsat #(
   parameter int unsigned ACC_W = 15,
   parameter int unsigned PIX_W = 8,
   parameter int unsigned SHIFT = 5
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [PIX_W-1:0]        pix
);

   localparam int unsigned EXT_W = ACC_W + 1;
   localparam logic signed [EXT_W-1:0] RND  = EXT_W'(1 << (SHIFT - 1));
   localparam logic signed [EXT_W-1:0] PMAX = EXT_W'((1 << PIX_W) - 1);

   logic signed [EXT_W-1:0] rounded;
   logic signed [EXT_W-1:0] scaled;

   assign rounded = {acc[ACC_W-1], acc} + RND;
   assign scaled  = rounded >>> SHIFT;

   always_comb begin
      if (scaled < 0) begin
         pix = '0;
      end else if (scaled > PMAX) begin
         pix = '1;
      end else begin
         pix = scaled[PIX_W-1:0];
      end
   end

endmodule

// File: rtl/halfpel_fir6.sv
module halfpel_fir6
   import halfpel_pkg::*;
#(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned ACC_W = min_acc_width(PIX_W),
   parameter int unsigned SHIFT = 5,
   parameter sum_arch_e   ARCH  = SUM_PREADD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] in_data,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_data
);

   // Elaboration-time parameter checks.
   if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix
      $error("halfpel_fir6: PIX_W out of supported range");
   end
   if (ACC_W < min_acc_width(PIX_W)) begin : g_bad_acc
      $error("halfpel_fir6: ACC_W too narrow for the weighted sum");
   end
   if (SHIFT < 1 || SHIFT >= ACC_W) begin : g_bad_shift
      $error("halfpel_fir6: SHIFT out of range");
   end

   logic [WIN_DEPTH-1:0][PIX_W-1:0] win_nxt;
   logic                            fire;
   logic signed [ACC_W-1:0]         acc;
   logic [PIX_W-1:0]                pix;

   hp_window #(.PIX_W(PIX_W), .DEPTH(WIN_DEPTH)) win_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clear),
      .push    (in_valid),
      .din     (in_data),
      .win_nxt (win_nxt),
      .fire    (fire)
   );

   hp_tapsum #(.PIX_W(PIX_W), .ACC_W(ACC_W), .ARCH(ARCH)) sum_i (
      .win (win_nxt),
      .acc (acc)
   );

   hp_normsat #(.ACC_W(ACC_W), .PIX_W(PIX_W), .SHIFT(SHIFT)) sat_i (
      .acc (acc),
      .pix (pix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_data <= pix;
         end
      end
   end

endmodule

// File: rtl/halfpel_fir6_chk.sv
module halfpel_fir6_chk #(
   parameter int unsigned PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             in_valid,
   input logic [PIX_W-1:0] in_data,
   input logic             out_valid,
   input logic [PIX_W-1:0] out_data
);

   // Accepted pixels since reset or clear, saturating at 7.
   logic [2:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (clear) begin
         seen_q <= '0;
      end else if (in_valid && seen_q != 3'd7) begin
         seen_q <= seen_q + 3'd1;
      end
   end

   assert_strobe_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && !clear));

   assert_clear_blocks_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !out_valid);

   assert_six_before_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (seen_q >= 3'd6));

   assert_full_window_streams_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q >= 3'd5 && in_valid && !clear) |=> out_valid);

   assert_idle_holds_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

   assert_idle_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (out_valid == 1'b0 && out_data == '0);
      end
   end

endmodule

bind halfpel_fir6 halfpel_fir6_chk #(.PIX_W(PIX_W)) chk_i (.*);

// File: tb/halfpel_fir6_tb_top.sv
module halfpel_fir6_tb_top;

   localparam int unsigned PIX_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clear = 1'b0;
   logic             in_valid = 1'b0;
   logic [PIX_W-1:0] in_data = '0;
   logic             out_valid;
   logic [PIX_W-1:0] out_data;

   always #4 clk = ~clk;  // 125 MHz

   halfpel_fir6 dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   int errors = 0;
   int checks = 0;

   // Reference state: hist[0] oldest ... hist[5] newest.
   int hist [6];
   int seen = 0;
   bit exp_valid = 0;
   int exp_data = 0;

   function automatic int ref_pix();
      int s;
      s = hist[0] - 5*hist[1] + 20*hist[2] + 20*hist[3] - 5*hist[4] + hist[5];
      s = (s + 16) >>> 5;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cycle on the falling edge, update the model at the rising edge,
   // compare at the next falling edge.
   task automatic step(input bit v, input int d, input bit f, input string req);
      in_valid = v;
      in_data  = PIX_W'(d);
      clear    = f;
      @(posedge clk);
      if (f) begin
         seen = 0;
         for (int i = 0; i < 6; i++) hist[i] = 0;
         exp_valid = 0;
      end else if (v) begin
         for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
         hist[5] = d;
         if (seen < 7) seen++;
         exp_valid = (seen >= 6);
         if (exp_valid) exp_data = ref_pix();
      end else begin
         exp_valid = 0;
      end
      @(negedge clk);
      check(out_valid == exp_valid, {req, " strobe"}, int'(out_valid), int'(exp_valid));
      check(int'(out_data) == exp_data, {req, " data"}, int'(out_data), exp_data);
      in_valid = 1'b0;
      clear    = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 6; i++) hist[i] = 0;
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      check(out_valid == 1'b0, "R1 strobe in reset", int'(out_valid), 0);
      check(out_data == '0, "R1 data in reset", int'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 strobe after release", int'(out_valid), 0);

      // R6: fill with zeros; first strobe after the sixth pixel
      for (int i = 0; i < 8; i++) step(1, 0, 0, "R6 zero fill");

      // R5: all-255 input stays at the top code
      for (int i = 0; i < 10; i++) step(1, 255, 0, "R5 all max");

      // R5: period-4 pattern 255,255,0,0 drives both clamps
      for (int i = 0; i < 24; i++) step(1, ((i % 4) < 2) ? 255 : 0, 0, "R5 clamp pattern");

      // R3: single alternation 0/255 (mid-range result)
      for (int i = 0; i < 12; i++) step(1, (i % 2) ? 255 : 0, 0, "R3 alternating");

      // R2: ramp through every pixel code, window order matters
      for (int v = 0; v < 256; v++) step(1, v, 0, "R2 ramp");

      // R4: impulse walks through every tap, exercises rounding
      for (int a = 1; a < 256; a += 37) begin
         for (int i = 0; i < 12; i++) step(1, (i == 5) ? a : 0, 0, "R4 impulse");
      end

      // R7: idle gaps hold data and window
      step(1, 90, 0, "R7 before gap");
      for (int i = 0; i < 4; i++) step(0, 255, 0, "R7 idle");
      step(1, 10, 0, "R7 after gap");

      // R8: clear with pixel in the same cycle, then refill
      step(1, 200, 1, "R8 clear with pixel");
      for (int i = 0; i < 7; i++) step(1, 30 + 7*i, 0, "R8 refill");
      step(1, 1, 1, "R8 clear again");
      for (int i = 0; i < 3; i++) step(1, 250, 0, "R8 partial");
      step(0, 0, 1, "R8 clear idle");
      for (int i = 0; i < 6; i++) step(1, 5*i, 0, "R8 refill two");

      // R9: mixed random stream with gaps and occasional clears
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         step(r < 70, int'($urandom_range(0, 255)), r >= 97, "R9 random mix");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule